// File: doc/BRIEF.md
# Minimal 32-bit Load/Store Processor

A single-cycle 32-bit processor with eight general registers. Each clock cycle it fetches one word from a small internal instruction memory and carries it out completely in that cycle. The word is one of three kinds. A memory access moves one 32-bit word between a register and a 256-word internal data memory. A register-register ALU operation performs add, subtract, or, xor, and or a signed compare. A branch jumps only when its two source registers hold equal values. An all-ones word halts the machine.

A controller uses the block as follows. While the synchronous reset is held, the controller loads a program and its data through two test write ports. It then releases reset and waits for `done`. When `done` is high, it reads the results back through a register peek port and the data memory test read port. A two-state machine governs execution. In `ST_RUN` the processor executes one instruction per cycle. The transition `RUN->HALT` fires on the halt word. `ST_HALT` holds the program counter and blocks every write until reset, which is the only way back (`HALT->RUN`).

Instruction word: bits [31:30] give the kind (00 memory, 01 ALU, 10 branch, 11 system). Bits [29:27] are rd, [26:24] rs and [23:21] rt. Bit 20 selects store (1) or load (0). Bits [15:0] are a signed offset, and bits [2:0] are the ALU operation.

Top module: `mcpu_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all eight registers to 0 and lowers `done`. Memory contents are kept.
- R2: The test write ports change instruction or data memory only in cycles where reset is high. At any other time their writes are ignored.
- R3: ALU operation codes are 000 add, 001 subtract (rs minus rt), 010 or, 011 xor and 100 and. Each writes rd from rs and rt, with 32-bit wrap-around.
- R4: ALU code 101 (compare) writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: ALU codes 110 and 111 write no register.
- R6: A load (kind 00, bit 20 = 0) writes rd with the data word at address (rs + sign-extended offset) modulo 256.
- R7: A store (kind 00, bit 20 = 1) writes register rt to the data word at address (rs + sign-extended offset) modulo 256.
- R8: A branch (kind 10) whose rs and rt are equal sets the program counter to PC + 1 + sign-extended offset, taken modulo the instruction memory depth. Backward offsets are allowed.
- R9: Any instruction that is not a taken branch or the halt word advances the program counter by one. This includes a branch with unequal registers.
- R10: The all-ones word halts the machine. `done` rises after that cycle, and from then until reset the program counter stays on the halt word and no register or memory is written.
- R11: A system-kind word (bits [31:30] = 11) other than all ones has no effect apart from advancing the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; enables test writes |
| tap_imem_we | input | 1 | Instruction memory test write enable |
| tap_imem_addr | input | 6 | Instruction memory test write address |
| tap_imem_data | input | 32 | Instruction memory test write data |
| tap_dmem_we | input | 1 | Data memory test write enable |
| tap_dmem_addr | input | 8 | Data memory test write/read address |
| tap_dmem_wdata | input | 32 | Data memory test write data |
| tap_dmem_rdata | output | 32 | Data word at `tap_dmem_addr` while in reset or halted |
| peek_reg_sel | input | 3 | Register index to observe |
| peek_reg_val | output | 32 | Contents of the selected register |
| pc_o | output | 6 | Current program counter (instruction word index) |
| done | output | 1 | High while in the halted state |

## Verification
The bench aims at the following corner cases:
- A signed-overflow add that must wrap.
- A compare whose operands differ only in sign. An unsigned comparator would write 1 where 0 is expected.
- Undefined ALU codes. A design that decodes them as some operation corrupts rd.
- A load at offset -1 that must wrap to data word 255.
- A store whose result is then reloaded.
- A forward branch that skips two words, a branch that is not taken, and a backward branch that lands on the halt word. Off-by-one program counter arithmetic would run a flag instruction or miss the halt.

After the halt, the bench confirms that the program counter and registers stay frozen. It then attempts test-port writes outside reset and checks that the data memory and a rerun of the program show no trace of them.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [1:0] {
        K_MEM = 2'b00,
        K_ALU = 2'b01,
        K_BEQ = 2'b10,
        K_SYS = 2'b11
    } kind_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_OR  = 3'd2;
    localparam logic [2:0] OP_XOR = 3'd3;
    localparam logic [2:0] OP_AND = 3'd4;
    localparam logic [2:0] OP_CMP = 3'd5;

endpackage

// File: rtl/mcpu_wordmem.sv
module mcpu_wordmem #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_c
);
    logic [W-1:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (we && wa == AW'(g)) begin
                q[g] <= wd;
            end
        end
    end

    assign rd_a = q[ra_a];
    assign rd_b = q[ra_b];
    assign rd_c = q[ra_c];

    // R6
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> q[$past(wa)] == $past(wd));
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] y,
    output logic         ok
);
    always_comb begin
        y  = '0;
        ok = 1'b1;
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            OP_CMP:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcpu_top.sv
module mcpu_top
    import mcpu_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 256,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int DAW = $clog2(DMEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tap_imem_we,
    input  logic [IAW-1:0]    tap_imem_addr,
    input  logic [XLEN-1:0]   tap_imem_data,
    input  logic              tap_dmem_we,
    input  logic [DAW-1:0]    tap_dmem_addr,
    input  logic [XLEN-1:0]   tap_dmem_wdata,
    output logic [XLEN-1:0]   tap_dmem_rdata,
    input  logic [RIDX_W-1:0] peek_reg_sel,
    output logic [XLEN-1:0]   peek_reg_val,
    output logic [IAW-1:0]    pc_o,
    output logic              done
);
    run_state_e state_q, state_nx;
    logic [IAW-1:0]  pc_q, pc_nx;
    logic [XLEN-1:0] instr, rs_val, rt_val, alu_y, dmem_rd, rf_wd, dmem_wd;
    logic [RIDX_W-1:0] f_rd, f_rs, f_rt;
    logic [15:0]     f_off;
    logic [2:0]      f_op;
    kind_e           kind;
    logic            is_halt, st_bit, exec, alu_ok, taken;
    logic            rf_we, dmem_we;
    logic [DAW-1:0]  eff_addr, dmem_wa, dmem_ra;

    // fetch
    mcpu_wordmem #(.DEPTH(IMEM_DEPTH), .W(XLEN)) u_imem (
        .clk(clk), .we(rst && tap_imem_we), .wa(tap_imem_addr),
        .wd(tap_imem_data), .ra(pc_q), .rd(instr)
    );

    // field split
    assign kind    = kind_e'(instr[31:30]);
    assign f_rd    = instr[29:27];
    assign f_rs    = instr[26:24];
    assign f_rt    = instr[23:21];
    assign st_bit  = instr[20];
    assign f_off   = instr[15:0];
    assign f_op    = instr[2:0];
    assign is_halt = &instr;

    mcpu_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .wa(f_rd), .wd(rf_wd),
        .ra_a(f_rs), .rd_a(rs_val), .ra_b(f_rt), .rd_b(rt_val),
        .ra_c(peek_reg_sel), .rd_c(peek_reg_val)
    );

    mcpu_alu #(.W(XLEN)) u_alu (
        .a(rs_val), .b(rt_val), .op(f_op), .y(alu_y), .ok(alu_ok)
    );

    assign eff_addr = rs_val[DAW-1:0] + f_off[DAW-1:0];

    mcpu_wordmem #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
        .clk(clk), .we(dmem_we), .wa(dmem_wa), .wd(dmem_wd),
        .ra(dmem_ra), .rd(dmem_rd)
    );
    assign tap_dmem_rdata = dmem_rd;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_nx;
            pc_q    <= pc_nx;
        end
    end

    // next state, next PC and control outputs
    always_comb begin
        state_nx = state_q;
        pc_nx    = pc_q;
        exec     = 1'b0;
        taken    = 1'b0;
        rf_we    = 1'b0;
        rf_wd    = alu_y;
        dmem_we  = 1'b0;
        dmem_wa  = eff_addr;
        dmem_wd  = rt_val;
        dmem_ra  = tap_dmem_addr;
        unique case (state_q)
            ST_RUN: begin
                if (is_halt) begin
                    state_nx = ST_HALT;
                end else begin
                    exec    = 1'b1;
                    dmem_ra = eff_addr;
                    unique case (kind)
                        K_MEM: begin
                            rf_we   = !st_bit;
                            rf_wd   = dmem_rd;
                            dmem_we = st_bit;
                        end
                        K_ALU: rf_we = alu_ok;
                        K_BEQ: taken = (rs_val == rt_val);
                        K_SYS: ;
                    endcase
                    pc_nx = taken ? pc_q + IAW'(1) + f_off[IAW-1:0]
                                  : pc_q + IAW'(1);
                end
            end
            ST_HALT: state_nx = ST_HALT;
        endcase
        if (rst) begin
            rf_we   = 1'b0;
            dmem_we = tap_dmem_we;
            dmem_wa = tap_dmem_addr;
            dmem_wd = tap_dmem_wdata;
            dmem_ra = tap_dmem_addr;
        end
    end

    assign done = (state_q == ST_HALT);
    assign pc_o = pc_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0) && !done);

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && !taken) |=> pc_o == $past(pc_o) + IAW'(1));

    // R8
    branch_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && taken) |=> pc_o == $past(pc_o) + IAW'(1) + $past(f_off[IAW-1:0]));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable(pc_o) && !rf_we && !dmem_we);

    // R4
    cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we && kind == K_ALU && f_op == OP_CMP) |-> rf_wd[XLEN-1:1] == '0);
endmodule

// File: tb/mcpu_top_bench.sv
module mcpu_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tap_imem_we = 1'b0;
    logic [5:0]  tap_imem_addr = '0;
    logic [31:0] tap_imem_data = '0;
    logic        tap_dmem_we = 1'b0;
    logic [7:0]  tap_dmem_addr = '0;
    logic [31:0] tap_dmem_wdata = '0;
    logic [31:0] tap_dmem_rdata;
    logic [2:0]  peek_reg_sel = '0;
    logic [31:0] peek_reg_val;
    logic [5:0]  pc_o;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    localparam logic [31:0] HALT = 32'hFFFF_FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcpu_top u_mcpu_top (
        .clk(clk), .rst(rst),
        .tap_imem_we(tap_imem_we), .tap_imem_addr(tap_imem_addr), .tap_imem_data(tap_imem_data),
        .tap_dmem_we(tap_dmem_we), .tap_dmem_addr(tap_dmem_addr), .tap_dmem_wdata(tap_dmem_wdata),
        .tap_dmem_rdata(tap_dmem_rdata),
        .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
        .pc_o(pc_o), .done(done)
    );

    function automatic logic [31:0] enc(input logic [1:0] k, input logic [2:0] rd,
                                        input logic [2:0] rs, input logic [2:0] rt,
                                        input logic st, input logic [15:0] off);
        return {k, rd, rs, rt, st, 4'b0000, off};
    endfunction
    function automatic logic [31:0] ld(input logic [2:0] rd, input logic [2:0] rs, input logic [15:0] off);
        return enc(2'b00, rd, rs, 3'd0, 1'b0, off);
    endfunction
    function automatic logic [31:0] st(input logic [2:0] rt, input logic [2:0] rs, input logic [15:0] off);
        return enc(2'b00, 3'd0, rs, rt, 1'b1, off);
    endfunction
    function automatic logic [31:0] alu(input logic [2:0] op, input logic [2:0] rd,
                                        input logic [2:0] rs, input logic [2:0] rt);
        return enc(2'b01, rd, rs, rt, 1'b0, {13'd0, op});
    endfunction
    function automatic logic [31:0] beq(input logic [2:0] rs, input logic [2:0] rt, input logic [15:0] off);
        return enc(2'b10, 3'd0, rs, rt, 1'b0, off);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic put_imem(input int a, input logic [31:0] w);
        @(negedge clk);
        tap_imem_we = 1'b1; tap_imem_addr = 6'(a); tap_imem_data = w;
        @(negedge clk);
        tap_imem_we = 1'b0;
    endtask

    task automatic put_dmem(input int a, input logic [31:0] w);
        @(negedge clk);
        tap_dmem_we = 1'b1; tap_dmem_addr = 8'(a); tap_dmem_wdata = w;
        @(negedge clk);
        tap_dmem_we = 1'b0;
    endtask

    task automatic reg_val(input int idx, output logic [31:0] v);
        peek_reg_sel = 3'(idx);
        #1 v = peek_reg_val;
    endtask

    task automatic mem_val(input int a, output logic [31:0] v);
        tap_dmem_addr = 8'(a);
        #1 v = tap_dmem_rdata;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_to_halt(input string req);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) break;
        end
        check(req, "done after run", {31'd0, done}, 32'd1);
    endtask

    task automatic load_data();
        put_dmem(0, 32'd5);
        put_dmem(1, 32'hFFFF_FFFD);
        put_dmem(2, 32'h0F0F_00FF);
        put_dmem(3, 32'h7FFF_FFFF);
        put_dmem(10, 32'd100);
        put_dmem(255, 32'd77);
    endtask

    // R3 add/sub/xor with wrap-around
    task automatic t_arith();
        logic [31:0] v;
        enter_reset();
        load_data();
        put_imem(0, ld(3'd1, 3'd0, 16'd0));
        put_imem(1, ld(3'd2, 3'd0, 16'd1));
        put_imem(2, ld(3'd3, 3'd0, 16'd2));
        put_imem(3, ld(3'd4, 3'd0, 16'd3));
        put_imem(4, alu(3'd0, 3'd5, 3'd4, 3'd1));
        put_imem(5, alu(3'd1, 3'd6, 3'd1, 3'd2));
        put_imem(6, alu(3'd3, 3'd7, 3'd3, 3'd2));
        put_imem(7, HALT);
        run_to_halt("R10");
        reg_val(4, v); check("R6", "load r4", v, 32'h7FFF_FFFF);
        reg_val(5, v); check("R3", "add wrap", v, 32'h7FFF_FFFF + 32'd5);
        reg_val(6, v); check("R3", "sub", v, 32'd5 - 32'hFFFF_FFFD);
        reg_val(7, v); check("R3", "xor", v, 32'h0F0F_00FF ^ 32'hFFFF_FFFD);
        check("R10", "pc on halt", {26'd0, pc_o}, 32'd7);
    endtask

    // R1 reset state, R3 logic ops, R4 signed compare, R5 undefined codes
    task automatic t_logic_cmp();
        logic [31:0] v;
        enter_reset();
        check("R1", "pc in reset", {26'd0, pc_o}, 32'd0);
        check("R1", "done in reset", {31'd0, done}, 32'd0);
        reg_val(5, v); check("R1", "r5 cleared", v, 32'd0);
        reg_val(7, v); check("R1", "r7 cleared", v, 32'd0);
        put_imem(0, ld(3'd1, 3'd0, 16'd0));
        put_imem(1, ld(3'd2, 3'd0, 16'd1));
        put_imem(2, ld(3'd3, 3'd0, 16'd2));
        put_imem(3, alu(3'd2, 3'd4, 3'd3, 3'd2));
        put_imem(4, alu(3'd4, 3'd5, 3'd3, 3'd2));
        put_imem(5, alu(3'd5, 3'd6, 3'd2, 3'd1));
        put_imem(6, alu(3'd5, 3'd7, 3'd1, 3'd2));
        put_imem(7, alu(3'd6, 3'd1, 3'd2, 3'd3));
        put_imem(8, alu(3'd7, 3'd2, 3'd3, 3'd3));
        put_imem(9, HALT);
        run_to_halt("R10");
        reg_val(4, v); check("R3", "or", v, 32'h0F0F_00FF | 32'hFFFF_FFFD);
        reg_val(5, v); check("R3", "and", v, 32'h0F0F_00FF & 32'hFFFF_FFFD);
        reg_val(6, v); check("R4", "cmp -3<5", v, 32'd1);
        reg_val(7, v); check("R4", "cmp 5<-3", v, 32'd0);
        reg_val(1, v); check("R5", "op 110 no write", v, 32'd5);
        reg_val(2, v); check("R5", "op 111 no write", v, 32'hFFFF_FFFD);
        check("R10", "pc on halt", {26'd0, pc_o}, 32'd9);
    endtask

    // R6/R7 memory, R8/R9 branches, R11 system no-op, R10 hold
    task automatic t_mem_branch();
        logic [31:0] v, r7_before;
        logic [5:0]  pc_before;
        enter_reset();
        put_imem(0,  ld(3'd1, 3'd0, 16'd10));
        put_imem(1,  ld(3'd2, 3'd0, 16'hFFFF));
        put_imem(2,  st(3'd1, 3'd2, 16'd3));
        put_imem(3,  ld(3'd3, 3'd0, 16'd80));
        put_imem(4,  beq(3'd1, 3'd3, 16'd2));
        put_imem(5,  alu(3'd0, 3'd4, 3'd1, 3'd1));
        put_imem(6,  alu(3'd0, 3'd4, 3'd1, 3'd1));
        put_imem(7,  beq(3'd1, 3'd2, 16'd5));
        put_imem(8,  alu(3'd0, 3'd5, 3'd1, 3'd2));
        put_imem(9,  32'hC000_0000);
        put_imem(10, beq(3'd0, 3'd0, 16'd1));
        put_imem(11, alu(3'd0, 3'd6, 3'd1, 3'd1));
        put_imem(12, beq(3'd0, 3'd0, 16'd2));
        put_imem(13, HALT);
        put_imem(14, alu(3'd0, 3'd6, 3'd1, 3'd1));
        put_imem(15, alu(3'd0, 3'd7, 3'd1, 3'd1));
        put_imem(16, beq(3'd0, 3'd0, 16'hFFFC));
        run_to_halt("R10");
        reg_val(2, v); check("R6", "load wraps to word 255", v, 32'd77);
        reg_val(3, v); check("R7", "stored word reloaded", v, 32'd100);
        mem_val(80, v); check("R7", "dmem[80]", v, 32'd100);
        reg_val(4, v); check("R8", "forward branch skipped", v, 32'd0);
        reg_val(5, v); check("R9", "not-taken branch falls through", v, 32'd177);
        reg_val(6, v); check("R11", "system word no-op then branch", v, 32'd0);
        reg_val(7, v); check("R8", "target reached", v, 32'd200);
        check("R8", "backward branch onto halt", {26'd0, pc_o}, 32'd13);
        pc_before = pc_o;
        reg_val(7, r7_before);
        repeat (5) @(negedge clk);
        check("R10", "pc frozen", {26'd0, pc_o}, {26'd0, pc_before});
        check("R10", "done held", {31'd0, done}, 32'd1);
        reg_val(7, v); check("R10", "r7 frozen", v, r7_before);
    endtask

    // R2 test writes outside reset are ignored
    task automatic t_tap_ignored();
        logic [31:0] v;
        put_dmem(10, 32'h0000_DEAD);
        put_imem(13, 32'h0000_0000);
        mem_val(10, v); check("R2", "dmem write while halted", v, 32'd100);
        enter_reset();
        run_to_halt("R2");
        check("R2", "imem write while halted left halt word", {26'd0, pc_o}, 32'd13);
        reg_val(1, v); check("R2", "rerun loads original word", v, 32'd100);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_arith();
        t_logic_cmp();
        t_mem_branch();
        t_tap_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule